// File: doc/BRIEF.md
# Failing Block Remap Stack

This block sits in a cache access path. It runs at an operating voltage below nominal, where some storage blocks can no longer hold data. A voltage search has already produced a minimum voltage code for every block. A configure pulse starts a build phase. During that phase the block latches the per-block codes, the operating code and a marginal threshold. It marks each block as failing, marginal or robust. It then sorts the non-failing blocks, one per cycle, into a stack. The stack is ordered by minimum code from highest to lowest, so the blocks with the least headroom sit on top and are handed out first.

After the build, a valid/ready request stream carries block indices. A functional block passes through unchanged. The first request to a failing block takes the block on top of the stack, moves the stack pointer down one entry and records the pairing in a remap table. Later requests to that failing block reuse the recorded target. When the stack runs out, a new failing block comes back as itself with an unmappable flag. The response is a valid/ready stream registered one cycle after acceptance. While a response is held by the consumer, no new request is accepted, so back-pressure passes straight upstream.

Top module: `blk_remap_stack`

## Requirements
- R1: After a build, `fail_mask` bit i is 1 exactly when block i's latched minimum code is greater than the latched operating code.
- R2: After a build, `marg_mask` bit i is 1 exactly when block i is not failing and (operating code minus its minimum code) is at most the latched threshold. All other non-failing blocks are robust.
- R3: A `cfg_start` pulse drops `cfg_ready` and `req_ready` at the next edge. `cfg_ready` returns within NUM_BLK+2 cycles. While `cfg_ready` is low, no request is accepted.
- R4: A request to a non-failing block returns that same index with `rsp_unmap` = 0.
- R5: The first request to a failing block returns the non-failing block with the highest minimum code. Among equal codes, the lower index comes first.
- R6: Each request to a failing block that has no mapping yet takes the next stack entry in the R5 order. No entry is given out twice.
- R7: Repeating a request to an already mapped failing block returns its recorded target and consumes no stack entry.
- R8: A request to an unmapped failing block when the stack is exhausted returns the requested index with `rsp_unmap` = 1.
- R9: `rsp_valid` rises in the cycle after a request is accepted (one registered stage).
- R10: While `rsp_valid` = 1 and `rsp_ready` = 0, the response holds stable and `req_ready` stays 0.
- R11: A new `cfg_start` erases all recorded mappings and refills the stack from the newly latched codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Pulse: latch codes and start the build |
| vmin_codes | input | NUM_BLK*CODE_W | Per-block minimum voltage codes, block i at bits [i*CODE_W +: CODE_W] |
| op_code | input | CODE_W | Operating voltage code |
| marg_thr | input | CODE_W | Headroom threshold for the marginal class |
| cfg_ready | output | 1 | Build finished; lookups enabled |
| fail_mask | output | NUM_BLK | Per-block failing flag |
| marg_mask | output | NUM_BLK | Per-block marginal flag |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_blk | input | IDX_W | Requested logical block |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_blk | output | IDX_W | Physical block to access |
| rsp_unmap | output | 1 | Failing block with no spare left |

## Verification
If the sorted stack is corrupt, the wrong physical index appears on the first remap response after the build, one cycle after that request is accepted. The directed sequences predict that exact index from a reference ordering. If the stack pointer or the remap table is wrong, the fault shows up on a repeated request or on the next fresh failing block. It appears as a target given out twice, a target that changed, or an `rsp_unmap` that comes too early or too late. If the masks are misclassified, the status pins differ as soon as `cfg_ready` rises. If the handshake is wrong, responses are lost or change while the consumer stalls.

// File: rtl/rmp_pkg.sv
package rmp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SORT = 2'd1,
    PH_DONE = 2'd2
  } sort_ph_e;
endpackage

// File: rtl/rmp_classify.sv
module rmp_classify #(
  parameter int NB = 8,
  parameter int CW = 4
) (
  input  logic [NB*CW-1:0] codes,
  input  logic [CW-1:0]    op,
  input  logic [CW-1:0]    thr,
  output logic [NB-1:0]    fail_m,
  output logic [NB-1:0]    marg_m
);
  for (genvar g = 0; g < NB; g++) begin : g_cls
    logic [CW-1:0] v;
    logic [CW-1:0] head;
    assign v         = codes[g*CW +: CW];
    assign fail_m[g] = (v > op);
    assign head      = op - v;
    assign marg_m[g] = !fail_m[g] && (head <= thr);
  end
endmodule

// File: rtl/rmp_sorter.sv
module rmp_sorter
  import rmp_pkg::*;
#(
  parameter int NB = 8,
  parameter int CW = 4,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1,
  localparam int NW = $clog2(NB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NB*CW-1:0] codes,
  input  logic [NB-1:0]    fail_m,
  output logic [NB*IW-1:0] stk_ids,
  output logic [NW-1:0]    stk_cnt,
  output logic             done
);
  sort_ph_e      ph_q;
  logic [CW-1:0] key_q [NB];
  logic [IW-1:0] id_q  [NB];
  logic [NW-1:0] cnt_q;
  logic [IW-1:0] step_q;

  logic [CW-1:0] cur_key;
  logic [NW-1:0] pos;
  logic [CW-1:0] nkey [NB];
  logic [IW-1:0] nid  [NB];

  assign cur_key = codes[step_q*CW +: CW];

  // Insertion point: count entries whose key is >= the new key (stable, descending)
  always_comb begin
    pos = '0;
    for (int j = 0; j < NB; j++)
      if (NW'(j) < cnt_q && key_q[j] >= cur_key) pos = pos + 1'b1;
    for (int j = 0; j < NB; j++) begin
      if (NW'(j) < pos) begin
        nkey[j] = key_q[j];
        nid[j]  = id_q[j];
      end else if (NW'(j) == pos) begin
        nkey[j] = cur_key;
        nid[j]  = step_q;
      end else begin
        nkey[j] = key_q[j-1];
        nid[j]  = id_q[j-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      step_q <= '0;
    end else if (start) begin
      ph_q   <= PH_SORT;
      cnt_q  <= '0;
      step_q <= '0;
    end else if (ph_q == PH_SORT) begin
      if (!fail_m[step_q]) cnt_q <= cnt_q + 1'b1;
      if (step_q == IW'(NB - 1)) ph_q <= PH_DONE;
      else step_q <= step_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ph_q == PH_SORT && !start && !fail_m[step_q]) begin
      for (int j = 0; j < NB; j++) begin
        key_q[j] <= nkey[j];
        id_q[j]  <= nid[j];
      end
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_out
    assign stk_ids[g*IW +: IW] = id_q[g];
  end
  assign stk_cnt = cnt_q;
  assign done    = (ph_q == PH_DONE);
endmodule

// File: rtl/rmp_lookup.sv
module rmp_lookup #(
  parameter int NB = 8,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1,
  localparam int NW = $clog2(NB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic [NB-1:0]    fail_m,
  input  logic [NB*IW-1:0] stk_ids,
  input  logic [NW-1:0]    stk_cnt,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IW-1:0]    req_blk,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [IW-1:0]    rsp_blk,
  output logic             rsp_unmap
);
  logic [NW-1:0] sp_q;
  logic [NB-1:0] map_vld_q;
  logic [IW-1:0] map_tgt_q [NB];
  logic [IW-1:0] stk [NB];
  logic [IW-1:0] top_id;
  logic          acc;
  logic          take;

  for (genvar g = 0; g < NB; g++) begin : g_unpack
    assign stk[g] = stk_ids[g*IW +: IW];
  end

  always_comb begin
    top_id = '0;
    for (int j = 0; j < NB; j++)
      if (NW'(j) == sp_q) top_id = stk[j];
  end

  assign req_ready = en && !clear && (!rsp_valid || rsp_ready);
  assign acc       = req_valid && req_ready;
  assign take      = acc && fail_m[req_blk] && !map_vld_q[req_blk] && (sp_q < stk_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_vld_q <= '0;
      sp_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_blk   <= '0;
      rsp_unmap <= 1'b0;
    end else if (clear) begin
      map_vld_q <= '0;
      sp_q      <= '0;
      rsp_valid <= 1'b0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      if (!fail_m[req_blk]) begin
        rsp_blk   <= req_blk;
        rsp_unmap <= 1'b0;
      end else if (map_vld_q[req_blk]) begin
        rsp_blk   <= map_tgt_q[req_blk];
        rsp_unmap <= 1'b0;
      end else if (take) begin
        rsp_blk            <= top_id;
        rsp_unmap          <= 1'b0;
        map_vld_q[req_blk] <= 1'b1;
        sp_q               <= sp_q + 1'b1;
      end else begin
        rsp_blk   <= req_blk;
        rsp_unmap <= 1'b1;
      end
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take && !clear) map_tgt_q[req_blk] <= top_id;
  end
endmodule

// File: rtl/blk_remap_stack.sv
module blk_remap_stack #(
  parameter int NUM_BLK = 8,
  parameter int CODE_W  = 4,
  localparam int IDX_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
  localparam int CNT_W  = $clog2(NUM_BLK + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_start,
  input  logic [NUM_BLK*CODE_W-1:0] vmin_codes,
  input  logic [CODE_W-1:0]         op_code,
  input  logic [CODE_W-1:0]         marg_thr,
  output logic                      cfg_ready,
  output logic [NUM_BLK-1:0]        fail_mask,
  output logic [NUM_BLK-1:0]        marg_mask,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [IDX_W-1:0]          req_blk,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [IDX_W-1:0]          rsp_blk,
  output logic                      rsp_unmap
);
  logic [NUM_BLK*CODE_W-1:0] codes_q;
  logic [CODE_W-1:0]         op_q;
  logic [CODE_W-1:0]         thr_q;
  logic [NUM_BLK*IDX_W-1:0]  stk_ids;
  logic [CNT_W-1:0]          stk_cnt;
  logic                      built;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codes_q <= '0;
      op_q    <= '0;
      thr_q   <= '0;
    end else if (cfg_start) begin
      codes_q <= vmin_codes;
      op_q    <= op_code;
      thr_q   <= marg_thr;
    end
  end

  rmp_classify #(.NB(NUM_BLK), .CW(CODE_W)) u_cls (
    .codes  (codes_q),
    .op     (op_q),
    .thr    (thr_q),
    .fail_m (fail_mask),
    .marg_m (marg_mask)
  );

  rmp_sorter #(.NB(NUM_BLK), .CW(CODE_W)) u_sort (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (cfg_start),
    .codes   (codes_q),
    .fail_m  (fail_mask),
    .stk_ids (stk_ids),
    .stk_cnt (stk_cnt),
    .done    (built)
  );

  rmp_lookup #(.NB(NUM_BLK)) u_look (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cfg_start),
    .en        (built),
    .fail_m    (fail_mask),
    .stk_ids   (stk_ids),
    .stk_cnt   (stk_cnt),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_blk   (req_blk),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_blk   (rsp_blk),
    .rsp_unmap (rsp_unmap)
  );

  assign cfg_ready = built;
endmodule

// File: rtl/blk_remap_chk.sv
module blk_remap_chk #(
  parameter int NB = 8,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_start,
  input logic          cfg_ready,
  input logic [NB-1:0] fail_mask,
  input logic          req_valid,
  input logic          req_ready,
  input logic [IW-1:0] req_blk,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [IW-1:0] rsp_blk,
  input logic          rsp_unmap
);
  assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cfg_ready);

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n || cfg_start)
    (req_valid && req_ready) |=> rsp_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n || cfg_start)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_blk) && $stable(rsp_unmap)));

  assert_pass_R4: assert property (@(posedge clk) disable iff (!rst_n || cfg_start)
    (req_valid && req_ready && !fail_mask[req_blk]) |=> (rsp_blk == $past(req_blk) && !rsp_unmap));

  assert_target_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_unmap) |-> !fail_mask[rsp_blk]);

  assert_unmap_self_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_unmap) |-> fail_mask[rsp_blk]);
endmodule

bind blk_remap_stack blk_remap_chk #(.NB(NUM_BLK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_start (cfg_start),
  .cfg_ready (cfg_ready),
  .fail_mask (fail_mask),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_blk   (req_blk),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_blk   (rsp_blk),
  .rsp_unmap (rsp_unmap)
);

// File: tb/sim_blk_remap_stack.sv
module sim_blk_remap_stack;
  localparam int NB = 8;
  localparam int CW = 4;
  localparam int IW = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_start = 0;
  logic [NB*CW-1:0] vmin_codes = '0;
  logic [CW-1:0] op_code = '0;
  logic [CW-1:0] marg_thr = '0;
  logic cfg_ready;
  logic [NB-1:0] fail_mask, marg_mask;
  logic req_valid = 0;
  logic req_ready;
  logic [IW-1:0] req_blk = '0;
  logic rsp_valid;
  logic rsp_ready = 1;
  logic [IW-1:0] rsp_blk;
  logic rsp_unmap;

  int n_chk = 0;
  int n_fail = 0;

  int m_stk [NB];
  int m_cnt, m_sp;
  bit m_vld [NB];
  int m_tgt [NB];
  int m_code [NB];
  int m_op, m_thr;

  always #10 clk = ~clk;

  blk_remap_stack #(.NUM_BLK(NB), .CODE_W(CW)) u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_build();
    m_cnt = 0; m_sp = 0;
    for (int v = (1 << CW) - 1; v >= 0; v--)
      for (int b = 0; b < NB; b++)
        if (m_code[b] == v && m_code[b] <= m_op) begin
          m_stk[m_cnt] = b; m_cnt++;
        end
    for (int b = 0; b < NB; b++) m_vld[b] = 0;
  endtask

  task automatic model_req(input int b, output int eb, output int eu);
    eu = 0;
    if (m_code[b] <= m_op) eb = b;
    else if (m_vld[b]) eb = m_tgt[b];
    else if (m_sp < m_cnt) begin
      eb = m_stk[m_sp]; m_vld[b] = 1; m_tgt[b] = eb; m_sp++;
    end else begin eb = b; eu = 1; end
  endtask

  task automatic configure(input int c0, c1, c2, c3, c4, c5, c6, c7, input int op, thr);
    int cyc;
    int fe, me;
    m_code = '{c0, c1, c2, c3, c4, c5, c6, c7};
    m_op = op; m_thr = thr;
    @(negedge clk);
    for (int b = 0; b < NB; b++) vmin_codes[b*CW +: CW] = CW'(m_code[b]);
    op_code = CW'(op); marg_thr = CW'(thr); cfg_start = 1;
    @(negedge clk);
    cfg_start = 0;
    check("R3 ready low after start", int'(cfg_ready), 0);
    check("R3 req_ready low in build", int'(req_ready), 0);
    cyc = 1;
    while (!cfg_ready && cyc < NB + 4) begin @(negedge clk); cyc++; end
    check("R3 ready within NB+2", int'(cyc <= NB + 2), 1);
    fe = 0; me = 0;
    for (int b = 0; b < NB; b++) begin
      if (m_code[b] > op) fe |= (1 << b);
      else if (op - m_code[b] <= thr) me |= (1 << b);
    end
    check("R1 fail_mask", int'(fail_mask), fe);
    check("R2 marg_mask", int'(marg_mask), me);
    model_build();
  endtask

  task automatic do_req(input string req, input int b);
    int eb, eu;
    model_req(b, eb, eu);
    @(negedge clk);
    check("R10 req_ready idle", int'(req_ready), 1);
    req_valid = 1; req_blk = IW'(b);
    @(negedge clk);
    req_valid = 0;
    check("R9 rsp_valid next cycle", int'(rsp_valid), 1);
    check({req, " rsp_blk"}, int'(rsp_blk), eb);
    check({req, " rsp_unmap"}, int'(rsp_unmap), eu);
  endtask

  task automatic t_reset();
    check("reset cfg_ready", int'(cfg_ready), 0);
    check("reset req_ready", int'(req_ready), 0);
    check("reset rsp_valid", int'(rsp_valid), 0);
  endtask

  task automatic t_scen_a();
    configure(5, 9, 3, 7, 9, 2, 10, 6, 8, 2);
    do_req("R4 direct", 0);
    do_req("R4 direct", 5);
    do_req("R5 first remap", 1);
    do_req("R6 second remap", 4);
    do_req("R7 repeat", 1);
    do_req("R6 third remap", 6);
    do_req("R7 repeat", 4);
  endtask

  task automatic t_backpressure();
    int eb, eu;
    model_req(2, eb, eu);
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_blk = 3'd2;
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < 3; k++) begin
      check("R10 held valid", int'(rsp_valid), 1);
      check("R10 held blk", int'(rsp_blk), eb);
      check("R10 req_ready low", int'(req_ready), 0);
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    check("R10 released", int'(rsp_valid), 0);
  endtask

  task automatic t_scen_b();
    configure(5, 9, 3, 7, 9, 2, 10, 6, 5, 1);
    do_req("R11 fresh remap", 1);
    do_req("R6 remap", 3);
    do_req("R6 remap", 4);
    do_req("R8 exhausted", 6);
    do_req("R8 exhausted", 7);
    do_req("R7 repeat", 3);
  endtask

  task automatic t_ties();
    configure(9, 3, 3, 3, 3, 3, 3, 3, 4, 0);
    do_req("R5 tie lowest index", 0);
    do_req("R4 direct", 1);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_scen_a();
    t_backpressure();
    t_scen_b();
    t_ties();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule